// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block follows the power state of one processor core. The core can be active, in one of two light idle states, in a clock-stop grant state, in one of three deeper idle levels, or in a one-cycle snoop-service state. Decoded idle requests move the core out of the active state. These are a halt, a monitor-wait that carries a target level, and level-read triggers. Wake sources and a monitor event bring the core back to active, but only while the active-low clock-stop request is released.

The block reports the current state as a 3-bit code. It also drives a clock-gate enable, a one-cycle acknowledge when the core enters the clock-stop grant state, and a strobe while a bus snoop is serviced out of halt. When the core leaves the grant state, it goes back to the state it held before entering, using a 2-bit return register. Reset is asynchronous and active low.

Top module: `core_idle_seq`

## Requirements
- R1: While rst_ni is low, state_o is 0 (active) and clk_gate_o, stopgnt_ack_o and snoop_svc_o are low. The block leaves reset in the active state.
- R2: State codes are active=0, halt=1, monitor-wait=2, grant=3, level-2=4, level-3=5, level-4=6, snoop=7. In active, with stpclk_ni high and no deeper request, mwait_i with mwait_hint_i=1 moves to 2, and otherwise halt_i moves to 1.
- R3: In active with stpclk_ni high, lvl_rd_i[0] or a monitor-wait with hint 2 moves to 4. lvl_rd_i[1] or hint 3 moves to 5. lvl_rd_i[2] or hint 4 moves to 6. A monitor-wait with a hint outside 1..4 is ignored.
- R4: In active, a low stpclk_ni takes precedence over every idle request. Among idle requests the deepest target wins: 6, then 5, 4, 2, 1.
- R5: A wake is (any bit of wake_i or mon_evt_i) AND stpclk_ni high. A wake moves states 1, 2, 4, 5 and 6 to active on the next edge. With stpclk_ni low there is no wake.
- R6: When stpclk_ni is low in states 0, 1 or 2 and no wake applies, the next state is 3 (grant).
- R7: In state 3, stpclk_ni high returns to the state (0, 1 or 2) from which 3 was entered. stpclk_ni low holds 3.
- R8: stpclk_ni has no effect in states 4, 5 and 6. Only a wake leaves them.
- R9: In state 1 with no wake and stpclk_ni high, snoop_req_i moves to 7 for exactly one cycle, with snoop_svc_o high, and the core then returns to 1. Idle requests are ignored in states 1, 2 and 3.
- R10: clk_gate_o is high in every state except 0 and 7.
- R11: stopgnt_ack_o is high for exactly the first cycle spent in state 3 after each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Decoded halt request |
| mwait_i | input | 1 | Decoded monitor-wait request |
| mwait_hint_i | input | HINT_W (3) | Target level of the monitor-wait |
| lvl_rd_i | input | 3 | Level-read triggers, bit 0 = level 2 .. bit 2 = level 4 |
| wake_i | input | N_WAKE (8) | Wake sources, OR-reduced |
| mon_evt_i | input | 1 | Armed-monitor event |
| stpclk_ni | input | 1 | Clock-stop request, active low |
| snoop_req_i | input | 1 | Bus snoop request |
| state_o | output | 3 | Current state code |
| clk_gate_o | output | 1 | Clock-gate enable |
| stopgnt_ack_o | output | 1 | Grant entry acknowledge, one cycle |
| snoop_svc_o | output | 1 | Snoop being serviced |

## Verification
Properties check on every cycle that the deep levels hold their state while no qualified wake is present. They also check that a wake never lands in active while the clock-stop request is low, that the snoop state always lasts one cycle and returns to halt, that grant exits only to codes 0 to 2, and that the acknowledge lines up with grant entry and lasts one cycle. Some behaviour can only be shown by the bench's scenarios: that grant returns to the exact state recorded on entry, the priority order when several requests arrive at once, ignored hint values, and the outputs during asynchronous reset. The bench checks these against a reference model driven by both directed and random stimulus.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_AHALT  = 3'd1,
    ST_MWAIT  = 3'd2,
    ST_STOPG  = 3'd3,
    ST_LVL2   = 3'd4,
    ST_LVL3   = 3'd5,
    ST_LVL4   = 3'd6,
    ST_SNOOP  = 3'd7
  } cis_state_e;

  localparam int unsigned NUM_DEEP  = 3;
  localparam int unsigned DEEP_BASE = 4;  // code of the shallowest deep level
  localparam int unsigned RET_W     = 2;
endpackage

// File: rtl/cis_break_det.sv
module cis_break_det #(
  parameter int unsigned N_WAKE = 8
) (
  input  logic [N_WAKE-1:0] wake_i,
  input  logic              mon_evt_i,
  input  logic              stpclk_ni,
  output logic              brk_o
);
  // wake only counts while the clock-stop line is released
  assign brk_o = (|wake_i | mon_evt_i) & stpclk_ni;
endmodule

// File: rtl/cis_idle_arb.sv
module cis_idle_arb
  import cis_pkg::*;
#(
  parameter int unsigned HINT_W = 3
) (
  input  logic                halt_i,
  input  logic                mwait_i,
  input  logic [HINT_W-1:0]   hint_i,
  input  logic [NUM_DEEP-1:0] lvl_rd_i,
  output logic                req_vld_o,
  output cis_state_e          tgt_o
);
  logic [NUM_DEEP-1:0] deep_hit;
  logic                mw1_hit;

  assign mw1_hit = mwait_i && (hint_i == HINT_W'(1));

  for (genvar k = 0; k < NUM_DEEP; k++) begin : g_deep
    assign deep_hit[k] = lvl_rd_i[k] | (mwait_i && (hint_i == HINT_W'(k + 2)));
  end

  always_comb begin
    req_vld_o = 1'b0;
    tgt_o     = ST_ACTIVE;
    if (halt_i) begin
      req_vld_o = 1'b1;
      tgt_o     = ST_AHALT;
    end
    if (mw1_hit) begin
      req_vld_o = 1'b1;
      tgt_o     = ST_MWAIT;
    end
    // later (deeper) hits override shallower ones
    for (int k = 0; k < NUM_DEEP; k++) begin
      if (deep_hit[k]) begin
        req_vld_o = 1'b1;
        tgt_o     = cis_state_e'(3'(DEEP_BASE + k));
      end
    end
  end
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
  import cis_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_i,
  input  logic       stpclk_ni,
  input  logic       snoop_req_i,
  input  logic       req_vld_i,
  input  cis_state_e tgt_i,
  output cis_state_e state_o,
  output logic       ack_o
);
  cis_state_e             st_q, st_d;
  logic [RET_W-1:0]       ret_q;
  logic                   ack_q;
  logic                   enter_sg;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACTIVE: begin
        if (!stpclk_ni)     st_d = ST_STOPG;
        else if (req_vld_i) st_d = tgt_i;
      end
      ST_AHALT: begin
        if (brk_i)            st_d = ST_ACTIVE;
        else if (!stpclk_ni)  st_d = ST_STOPG;
        else if (snoop_req_i) st_d = ST_SNOOP;
      end
      ST_MWAIT: begin
        if (brk_i)           st_d = ST_ACTIVE;
        else if (!stpclk_ni) st_d = ST_STOPG;
      end
      ST_STOPG: begin
        if (stpclk_ni) st_d = cis_state_e'({1'b0, ret_q});
      end
      ST_LVL2, ST_LVL3, ST_LVL4: begin
        if (brk_i) st_d = ST_ACTIVE;
      end
      ST_SNOOP: st_d = ST_AHALT;
      default:  st_d = ST_ACTIVE;
    endcase
  end

  assign enter_sg = (st_d == ST_STOPG) && (st_q != ST_STOPG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ACTIVE;
      ret_q <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= enter_sg;
      if (enter_sg) ret_q <= st_q[RET_W-1:0];
    end
  end

  assign state_o = st_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cis_pkg::*;
#(
  parameter int unsigned N_WAKE = 8,
  parameter int unsigned HINT_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_i,
  input  logic                mwait_i,
  input  logic [HINT_W-1:0]   mwait_hint_i,
  input  logic [NUM_DEEP-1:0] lvl_rd_i,
  input  logic [N_WAKE-1:0]   wake_i,
  input  logic                mon_evt_i,
  input  logic                stpclk_ni,
  input  logic                snoop_req_i,
  output logic [2:0]          state_o,
  output logic                clk_gate_o,
  output logic                stopgnt_ack_o,
  output logic                snoop_svc_o
);
  logic       brk;
  logic       req_vld;
  cis_state_e tgt;
  cis_state_e st;

  cis_break_det #(.N_WAKE(N_WAKE)) i_brk (
    .wake_i    (wake_i),
    .mon_evt_i (mon_evt_i),
    .stpclk_ni (stpclk_ni),
    .brk_o     (brk)
  );

  cis_idle_arb #(.HINT_W(HINT_W)) i_arb (
    .halt_i    (halt_i),
    .mwait_i   (mwait_i),
    .hint_i    (mwait_hint_i),
    .lvl_rd_i  (lvl_rd_i),
    .req_vld_o (req_vld),
    .tgt_o     (tgt)
  );

  cis_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .brk_i       (brk),
    .stpclk_ni   (stpclk_ni),
    .snoop_req_i (snoop_req_i),
    .req_vld_i   (req_vld),
    .tgt_i       (tgt),
    .state_o     (st),
    .ack_o       (stopgnt_ack_o)
  );

  assign state_o     = st;
  assign clk_gate_o  = (st != ST_ACTIVE) && (st != ST_SNOOP);
  assign snoop_svc_o = (st == ST_SNOOP);
endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
  parameter int unsigned N_WAKE = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_WAKE-1:0] wake_i,
  input logic              mon_evt_i,
  input logic              stpclk_ni,
  input logic [2:0]        state_o,
  input logic              clk_gate_o,
  input logic              stopgnt_ack_o,
  input logic              snoop_svc_o
);
  logic deep, light;
  assign deep  = state_o inside {3'd4, 3'd5, 3'd6};
  assign light = state_o inside {3'd1, 3'd2};

  AST_DEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep && !((|wake_i | mon_evt_i) && stpclk_ni)) |=> (state_o == $past(state_o))); // R8

  AST_NO_WAKE_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((deep || light) && !stpclk_ni) |=> (state_o != 3'd0)); // R5

  AST_SNOOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd7) |=> (state_o == 3'd1)); // R9

  AST_SNOOP_STROBE_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_svc_o |-> !clk_gate_o); // R10

  AST_GRANT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && stpclk_ni) |=> (state_o inside {3'd0, 3'd1, 3'd2})); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopgnt_ack_o |=> !stopgnt_ack_o); // R11

  AST_ACK_IN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopgnt_ack_o |-> (state_o == 3'd3)); // R11
endmodule

bind core_idle_seq cis_checker #(.N_WAKE(N_WAKE)) i_cis_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wake_i        (wake_i),
  .mon_evt_i     (mon_evt_i),
  .stpclk_ni     (stpclk_ni),
  .state_o       (state_o),
  .clk_gate_o    (clk_gate_o),
  .stopgnt_ack_o (stopgnt_ack_o),
  .snoop_svc_o   (snoop_svc_o)
);

// File: tb/test_core_idle_seq.sv
module test_core_idle_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_WAKE     = 8;
  localparam int HINT_W     = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              halt_i, mwait_i, mon_evt_i, stpclk_ni, snoop_req_i;
  logic [HINT_W-1:0] mwait_hint_i;
  logic [2:0]        lvl_rd_i;
  logic [N_WAKE-1:0] wake_i;
  logic [2:0]        state_o;
  logic              clk_gate_o, stopgnt_ack_o, snoop_svc_o;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_st;
  logic [1:0] m_ret;
  logic       m_ack;
  string      m_tag;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  core_idle_seq #(.N_WAKE(N_WAKE), .HINT_W(HINT_W)) i_core_idle_seq (
    .clk_i, .rst_ni, .halt_i, .mwait_i, .mwait_hint_i, .lvl_rd_i, .wake_i,
    .mon_evt_i, .stpclk_ni, .snoop_req_i, .state_o, .clk_gate_o,
    .stopgnt_ack_o, .snoop_svc_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(state_o == m_st, {m_tag, " state"}, state_o, m_st);
    chk(clk_gate_o == (m_st != 3'd0 && m_st != 3'd7), "R10 clk_gate", clk_gate_o,
        int'(m_st != 3'd0 && m_st != 3'd7));
    chk(stopgnt_ack_o == m_ack, "R11 ack", stopgnt_ack_o, m_ack);
    chk(snoop_svc_o == (m_st == 3'd7), "R9 snoop_svc", snoop_svc_o, int'(m_st == 3'd7));
  endtask

  // reference model of one clock edge
  task automatic model_step();
    logic       brk, mw1, d2, d3, d4;
    logic [2:0] nx;
    brk = (|wake_i | mon_evt_i) & stpclk_ni;
    mw1 = mwait_i && mwait_hint_i == 3'd1;
    d2  = lvl_rd_i[0] | (mwait_i && mwait_hint_i == 3'd2);
    d3  = lvl_rd_i[1] | (mwait_i && mwait_hint_i == 3'd3);
    d4  = lvl_rd_i[2] | (mwait_i && mwait_hint_i == 3'd4);
    nx  = m_st;
    case (m_st)
      3'd0: begin
        if (!stpclk_ni) begin nx = 3'd3; m_tag = "R6"; end
        else begin
          if (d4) nx = 3'd6; else if (d3) nx = 3'd5; else if (d2) nx = 3'd4;
          else if (mw1) nx = 3'd2; else if (halt_i) nx = 3'd1;
          if ($countones({halt_i, mw1, d2, d3, d4}) > 1) m_tag = "R4";
          else if (d2 | d3 | d4) m_tag = "R3";
          else if (mw1 | halt_i) m_tag = "R2";
          else m_tag = "R3";
        end
      end
      3'd1, 3'd2: begin
        if (brk) begin nx = 3'd0; m_tag = "R5"; end
        else if (!stpclk_ni) begin nx = 3'd3; m_tag = "R6"; end
        else if (m_st == 3'd1 && snoop_req_i) begin nx = 3'd7; m_tag = "R9"; end
        else m_tag = "R9";
      end
      3'd3: begin
        if (stpclk_ni) begin nx = {1'b0, m_ret}; m_tag = "R7"; end
        else m_tag = "R7";
      end
      3'd4, 3'd5, 3'd6: begin
        if (brk) begin nx = 3'd0; m_tag = "R5"; end
        else m_tag = "R8";
      end
      default: begin nx = 3'd1; m_tag = "R9"; end
    endcase
    m_ack = (nx == 3'd3) && (m_st != 3'd3);
    if (m_ack) m_ret = m_st[1:0];
    m_st = nx;
  endtask

  task automatic quiet();
    halt_i = 0; mwait_i = 0; mwait_hint_i = 0; lvl_rd_i = 0;
    wake_i = 0; mon_evt_i = 0; snoop_req_i = 0;
  endtask

  task automatic step();
    model_step();
    @(negedge clk_i);
    check_outputs();
    quiet();
  endtask

  task automatic do_reset();
    rst_ni = 0;
    #1;
    m_st = 0; m_ret = 0; m_ack = 0; m_tag = "R1";
    chk(state_o == 3'd0, "R1 state in reset", state_o, 0);
    chk({clk_gate_o, stopgnt_ack_o, snoop_svc_o} == 3'b000, "R1 outputs in reset",
        {clk_gate_o, stopgnt_ack_o, snoop_svc_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1d5e_a001;
    void'($urandom(seed));
    quiet();
    stpclk_ni = 1;
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    do_reset();

    // R2 halt, R9 snoop detour and ignored requests
    halt_i = 1; step();
    lvl_rd_i = 3'b111; halt_i = 1; step();
    snoop_req_i = 1; step();
    step();
    // R6/R11/R7 grant from halt and back
    stpclk_ni = 0; step(); step();
    stpclk_ni = 1; step();
    wake_i = 8'h80; step();                         // R5 back to active
    // R4 priority: all requests at once
    halt_i = 1; mwait_i = 1; mwait_hint_i = 1; lvl_rd_i = 3'b111; step();
    // R8 clock-stop ignored in level 4, R5 wake gated
    stpclk_ni = 0; wake_i = 8'h01; step();
    stpclk_ni = 1; step();
    mon_evt_i = 1; step();
    // R4 stop beats idle request
    stpclk_ni = 0; halt_i = 1; step();
    stpclk_ni = 1; step();
    // R2 monitor-wait light, grant round trip returns to it (R7)
    mwait_i = 1; mwait_hint_i = 1; step();
    stpclk_ni = 0; step();
    stpclk_ni = 1; step();
    wake_i = 8'h10; step();
    // R3 invalid hint ignored, hint 3 and level reads
    mwait_i = 1; mwait_hint_i = 5; step();
    mwait_i = 1; mwait_hint_i = 3; step();
    mon_evt_i = 1; step();
    lvl_rd_i = 3'b001; step();
    // R1 async reset from a deep level
    do_reset();
    step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      halt_i       = ($urandom % 4) == 0;
      mwait_i      = ($urandom % 4) == 0;
      mwait_hint_i = 3'($urandom % 8);
      lvl_rd_i     = (($urandom % 3) == 0) ? 3'($urandom % 8) : 3'b000;
      wake_i       = (($urandom % 6) == 0) ? N_WAKE'(1) << ($urandom % N_WAKE) : '0;
      mon_evt_i    = ($urandom % 10) == 0;
      snoop_req_i  = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) stpclk_ni = ~stpclk_ni;
      if (i % 1500 == 1499) do_reset();
      else step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule